// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache that sits between a processor load/store port and a wider memory port. Each 64-byte line holds one tag and is split into two 32-byte halves, and each half has its own valid flag. The tag, both half-valid flags and one dirty flag for the line are stored together in one status entry. The default capacity is 32 KB in 512 lines. Tag, status and data storage are behavioural arrays inside the block.

The processor presents a word address and holds the request until it is acknowledged. A hit is acknowledged in the same cycle with no added wait. A hit needs two things: the stored tag equals the request tag, and the half selected by the address has its valid flag set. On any other request the block stalls and works with memory one half-line at a time. It first writes back the valid halves of a dirty victim, then fetches only the requested half.

Writes allocate on a miss and mark the line dirty. Memory sees only half-line traffic, 256 bits per transfer, over a request/acknowledge handshake.

Top module: `sb_dcache`

## Requirements
- R1: An active-low asynchronous reset clears every valid flag and every dirty flag; during reset and right after it `cpu_ack_o` and `mem_req_o` are 0, and the first access to a line fetches from memory.
- R2: The address fields are: tag = bits [31:15], set index = bits [14:6], half select = bit 5, word select = bits [4:2]. A read hit acknowledges in the same cycle the request is presented, returns the addressed word and issues no memory traffic.
- R3: A read miss fetches exactly one 256-bit half-line, at the request address with bits [4:0] cleared, and then acknowledges with the addressed word.
- R4: When the tag matches but the addressed half is invalid, only that half is fetched (no write-back); the other half keeps its valid state and data and still hits afterwards.
- R5: A write hit replaces the whole addressed 32-bit word, sets the line's dirty flag and issues no memory traffic; a later read returns the new word.
- R6: A write miss first fetches the addressed half-line and then merges the word into it; the other words of that half keep their memory values.
- R7: On a tag mismatch with a dirty victim, each valid half of the victim is written back before the fetch, half 0 before half 1, one 256-bit memory write per half, at the victim tag's address, carrying the latest written data.
- R8: On a tag mismatch with a clean victim, no write-back occurs and exactly one half-line is fetched.
- R9: Loading a new tag clears both valid flags and the dirty flag, so the other half of the new line misses on its first access.
- R10: While `mem_req_o` is high and `mem_ack_i` is low, the address and direction held on the memory port stay stable; read data is taken in the cycle `mem_ack_i` is high, and word w of a half-line sits at bits [32w+31:32w].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = word write, 0 = word read |
| cpu_addr_i | input | 32 | Byte address of the word |
| cpu_wdata_i | input | 32 | Write data |
| cpu_ack_o | output | 1 | Request completes at this clock edge |
| cpu_rdata_o | output | 32 | Read data, valid with the acknowledge |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = write back a half-line, 0 = fetch |
| mem_addr_o | output | 32 | Half-line aligned memory address |
| mem_wdata_o | output | 256 | Half-line write-back data |
| mem_ack_i | input | 1 | Memory transfer completes at this edge |
| mem_rdata_i | input | 256 | Fetched half-line, valid with the acknowledge |

## Verification
One set index is driven through a chain of tags, so that each kind of access can be told apart by the memory traffic it causes. Repeat reads separate a hit (no traffic) from a cold miss (one fetch). A read of the sibling half under the same tag separates a half-level miss (one fetch) from a whole-line replacement. Evictions of dirty lines with both halves valid, dirty lines with one half valid, and clean lines separate write-back of two halves, one half and none, and the written-back data is compared against a reference memory. A write miss followed by reads of neighbouring words shows that the fetch and the merged word coexist.

// File: rtl/sb_dcache_pkg.sv
package sb_dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL
  } sb_state_e;
endpackage

// File: rtl/sb_tag_store.sv
module sb_tag_store #(
  parameter int NUM_SETS = 512,
  parameter int IDX_W    = 9,
  parameter int TAG_W    = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             sub_i,
  input  logic             install_i,
  input  logic             set_vld_i,
  input  logic             set_dirty_i,
  output logic             hit_o,
  output logic             tag_eq_o,
  output logic [1:0]       line_vld_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] vic_tag_o
);
  logic [TAG_W-1:0]         tag_q [NUM_SETS];
  logic [NUM_SETS-1:0][1:0] vld_q;
  logic [NUM_SETS-1:0]      dirty_q;

  always_ff @(posedge clk_i) begin
    if (install_i) tag_q[idx_i] <= tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else begin
      if (install_i) begin
        vld_q[idx_i]   <= 2'b00;
        dirty_q[idx_i] <= 1'b0;
      end
      if (set_vld_i)   vld_q[idx_i][sub_i] <= 1'b1;
      if (set_dirty_i) dirty_q[idx_i]      <= 1'b1;
    end
  end

  assign vic_tag_o  = tag_q[idx_i];
  assign tag_eq_o   = (vic_tag_o == tag_i);
  assign line_vld_o = vld_q[idx_i];
  assign dirty_o    = dirty_q[idx_i];
  // half-valid mux runs beside the comparator
  assign hit_o      = tag_eq_o & line_vld_o[sub_i];

  a_r4_other_half_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vld_i && !install_i) |=>
      (vld_q[$past(idx_i)][~$past(sub_i)] == $past(vld_q[idx_i][~sub_i])));

  a_r5_write_sets_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_dirty_i |=> dirty_q[$past(idx_i)]);
endmodule

// File: rtl/sb_data_store.sv
module sb_data_store #(
  parameter int NUM_SETS = 512,
  parameter int IDX_W    = 9,
  parameter int SUB_W    = 256,
  parameter int WORD_W   = 32,
  parameter int WSEL_W   = 3
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rd_sub_i,
  input  logic              wr_sub_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic              fill_i,
  input  logic [SUB_W-1:0]  fill_data_i,
  input  logic              wr_word_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [SUB_W-1:0]  sub_data_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int ENTRIES = NUM_SETS * 2;

  logic [SUB_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      mem_q[{idx_i, wr_sub_i}] <= fill_data_i;
    end else if (wr_word_i) begin
      mem_q[{idx_i, wr_sub_i}][wsel_i*WORD_W +: WORD_W] <= wr_data_i;
    end
  end

  assign sub_data_o = mem_q[{idx_i, rd_sub_i}];
  assign word_o     = sub_data_o[wsel_i*WORD_W +: WORD_W];
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 9,
  parameter int TAG_W  = 17,
  parameter int OFF_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ack_o,
  input  logic              hit_i,
  input  logic              tag_eq_i,
  input  logic [1:0]        line_vld_i,
  input  logic              dirty_i,
  input  logic [TAG_W-1:0]  vic_tag_i,
  output logic              install_o,
  output logic              set_vld_o,
  output logic              set_dirty_o,
  output logic              wr_word_o,
  output logic              fill_o,
  output logic              rd_sub_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i
);
  localparam int SUB_BIT = OFF_W - 1;

  sb_state_e state_q, state_d;
  logic      wb_sub_q, wb_sub_d;

  logic [IDX_W-1:0] idx;
  logic             req_sub;
  assign idx     = cpu_addr_i[OFF_W +: IDX_W];
  assign req_sub = cpu_addr_i[SUB_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wb_sub_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      wb_sub_q <= wb_sub_d;
    end
  end

  always_comb begin
    state_d     = state_q;
    wb_sub_d    = wb_sub_q;
    cpu_ack_o   = 1'b0;
    install_o   = 1'b0;
    set_vld_o   = 1'b0;
    set_dirty_o = 1'b0;
    wr_word_o   = 1'b0;
    fill_o      = 1'b0;
    rd_sub_o    = req_sub;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {cpu_addr_i[ADDR_W-1:SUB_BIT], {SUB_BIT{1'b0}}};
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_i) begin
          if (hit_i) begin
            cpu_ack_o = 1'b1;
            if (cpu_we_i) begin
              wr_word_o   = 1'b1;
              set_dirty_o = 1'b1;
            end
          end else if (!tag_eq_i || line_vld_i == 2'b00) begin
            if (dirty_i) begin
              wb_sub_d = ~line_vld_i[0];
              state_d  = ST_WB;
            end else begin
              install_o = 1'b1;
              state_d   = ST_FILL;
            end
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_WB: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        rd_sub_o   = wb_sub_q;
        mem_addr_o = {vic_tag_i, idx, wb_sub_q, {SUB_BIT{1'b0}}};
        if (mem_ack_i) begin
          if (!wb_sub_q && line_vld_i[1]) begin
            wb_sub_d = 1'b1;
          end else begin
            install_o = 1'b1;
            state_d   = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          fill_o    = 1'b1;
          set_vld_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  a_r2_ack_without_traffic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> !mem_req_o);

  a_r3_fill_then_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && mem_ack_i) |=> hit_i);

  a_r7_writeback_is_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |->
      (mem_addr_o[ADDR_W-1 -: TAG_W] != cpu_addr_i[ADDR_W-1 -: TAG_W]));

  a_r10_request_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: rtl/sb_dcache.sv
module sb_dcache #(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 512,
  parameter int SUB_BYTES  = 32,
  parameter int WORD_BYTES = 4,
  parameter int SUB_W      = SUB_BYTES * 8,
  parameter int WORD_W     = WORD_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [SUB_W-1:0]  mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [SUB_W-1:0]  mem_rdata_i
);
  localparam int IDX_W   = $clog2(NUM_SETS);
  localparam int BOFF_W  = $clog2(WORD_BYTES);
  localparam int WSEL_W  = $clog2(SUB_BYTES / WORD_BYTES);
  localparam int OFF_W   = $clog2(SUB_BYTES) + 1;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int SUB_BIT = OFF_W - 1;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic              unused_byte_bits;

  assign idx  = cpu_addr_i[OFF_W +: IDX_W];
  assign tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign wsel = cpu_addr_i[BOFF_W +: WSEL_W];
  assign unused_byte_bits = ^cpu_addr_i[BOFF_W-1:0];

  logic             hit, tag_eq, dirty;
  logic [1:0]       line_vld;
  logic [TAG_W-1:0] vic_tag;
  logic             install, set_vld, set_dirty, wr_word, fill, rd_sub;

  sb_tag_store #(
    .NUM_SETS(NUM_SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (idx),
    .tag_i      (tag),
    .sub_i      (cpu_addr_i[SUB_BIT]),
    .install_i  (install),
    .set_vld_i  (set_vld),
    .set_dirty_i(set_dirty),
    .hit_o      (hit),
    .tag_eq_o   (tag_eq),
    .line_vld_o (line_vld),
    .dirty_o    (dirty),
    .vic_tag_o  (vic_tag)
  );

  sb_data_store #(
    .NUM_SETS(NUM_SETS), .IDX_W(IDX_W), .SUB_W(SUB_W),
    .WORD_W(WORD_W), .WSEL_W(WSEL_W)
  ) u_data (
    .clk_i      (clk_i),
    .idx_i      (idx),
    .rd_sub_i   (rd_sub),
    .wr_sub_i   (cpu_addr_i[SUB_BIT]),
    .wsel_i     (wsel),
    .fill_i     (fill),
    .fill_data_i(mem_rdata_i),
    .wr_word_i  (wr_word),
    .wr_data_i  (cpu_wdata_i),
    .sub_data_o (mem_wdata_o),
    .word_o     (cpu_rdata_o)
  );

  sb_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_req_i  (cpu_req_i),
    .cpu_we_i   (cpu_we_i),
    .cpu_addr_i (cpu_addr_i),
    .cpu_ack_o  (cpu_ack_o),
    .hit_i      (hit),
    .tag_eq_i   (tag_eq),
    .line_vld_i (line_vld),
    .dirty_i    (dirty),
    .vic_tag_i  (vic_tag),
    .install_o  (install),
    .set_vld_o  (set_vld),
    .set_dirty_o(set_dirty),
    .wr_word_o  (wr_word),
    .fill_o     (fill),
    .rd_sub_o   (rd_sub),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!cpu_ack_o || hit));
endmodule

// File: tb/sb_dcache_test.sv
module sb_dcache_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic         cpu_ack;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [255:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [255:0] mem_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  sb_dcache uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int total = 0, bad = 0;
  int fill_cnt = 0, wb_cnt = 0, ack_cnt = 0, stab_bad = 0;
  bit finished = 0;
  logic [31:0] last_fill = '0;
  logic [31:0] wb_addr_q [$];
  logic [31:0] exp_q [$];
  string       rq_q [$];
  logic [31:0] bmem [logic [31:0]];
  logic [31:0] rmem [logic [31:0]];

  function automatic logic [31:0] iw(logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : iw(a);
  endfunction
  function automatic logic [31:0] ref_rd(logic [31:0] a);
    return rmem.exists(a) ? rmem[a] : iw(a);
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // memory responder: acknowledges each transfer after three cycles
  initial begin
    int dly = 0;
    logic [31:0] held_a = '0;
    logic held_w = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        dly = 0;
      end else if (mem_req) begin
        if (dly == 0) begin
          held_a = mem_addr;
          held_w = mem_we;
        end else if (mem_addr != held_a || mem_we != held_w) begin
          stab_bad++;
        end
        if (dly == 2) begin
          if (mem_we) begin
            for (int w = 0; w < 8; w++) bmem[mem_addr + 32'(4*w)] = mem_wdata[32*w +: 32];
            wb_cnt++;
            wb_addr_q.push_back(mem_addr);
          end else begin
            for (int w = 0; w < 8; w++) mem_rdata[32*w +: 32] = mem_rd(mem_addr + 32'(4*w));
            fill_cnt++;
            last_fill = mem_addr;
          end
          mem_ack = 1'b1;
        end
        dly++;
      end
    end
  end

  // monitor: pops expected read data on each acknowledge
  initial begin
    forever begin
      @(negedge clk);
      #7;
      if (cpu_req && cpu_ack) begin
        ack_cnt++;
        if (!cpu_we) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected read ack", cpu_rdata, 32'h0);
          end else begin
            logic [31:0] e;
            string r;
            e = exp_q.pop_front();
            r = rq_q.pop_front();
            chk(cpu_rdata == e, r, cpu_rdata, e);
          end
        end
      end
    end
  end

  // driver: one processor access, then traffic and latency checks
  task automatic access(bit we, logic [31:0] a, logic [31:0] d,
                        int efill, int ewb, int elat, string rq);
    int f0, w0, n, lat;
    f0 = fill_cnt; w0 = wb_cnt; n = ack_cnt; lat = 0;
    if (we) rmem[a] = d;
    else begin
      exp_q.push_back(ref_rd(a));
      rq_q.push_back(rq);
    end
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do begin
      @(negedge clk);
      lat++;
    end while (ack_cnt == n);
    cpu_req = 1'b0;
    chk(fill_cnt - f0 == efill, {rq, " fetch count"}, 32'(fill_cnt - f0), 32'(efill));
    chk(wb_cnt - w0 == ewb, {rq, " write-back count"}, 32'(wb_cnt - w0), 32'(ewb));
    if (elat > 0) chk(lat == elat, {rq, " latency"}, 32'(lat), 32'(elat));
  endtask

  initial begin
    #(20 * 60000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa;
    repeat (2) @(negedge clk);
    #7;
    chk(!cpu_ack && !mem_req, "R1 quiet in reset", {30'd0, cpu_ack, mem_req}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!cpu_ack && !mem_req, "R1 quiet after reset", {30'd0, cpu_ack, mem_req}, 32'd0);

    // tag1 set5: 0x8140 half0, 0x8160 half1
    access(0, 32'h0000_8144, 0, 1, 0, 0, "R1 R3 cold read miss");
    chk(last_fill == 32'h0000_8140, "R3 fetch address aligned", last_fill, 32'h0000_8140);
    access(0, 32'h0000_8144, 0, 0, 0, 1, "R2 read hit");
    access(0, 32'h0000_8168, 0, 1, 0, 0, "R4 sibling half miss");
    chk(last_fill == 32'h0000_8160, "R4 fetch of half1", last_fill, 32'h0000_8160);
    access(0, 32'h0000_815C, 0, 0, 0, 1, "R4 half0 still valid");
    access(1, 32'h0000_8148, 32'hDEAD_BEEF, 0, 0, 1, "R5 write hit half0");
    access(1, 32'h0000_8170, 32'h1234_5678, 0, 0, 1, "R5 write hit half1");
    access(0, 32'h0000_8148, 0, 0, 0, 1, "R5 read back written word");

    // tag2 evicts dirty line with both halves valid
    access(0, 32'h0001_0144, 0, 1, 2, 0, "R7 dirty eviction two halves");
    wa = (wb_addr_q.size() > 0) ? wb_addr_q.pop_front() : 32'hFFFF_FFFF;
    chk(wa == 32'h0000_8140, "R7 first write-back half0", wa, 32'h0000_8140);
    wa = (wb_addr_q.size() > 0) ? wb_addr_q.pop_front() : 32'hFFFF_FFFF;
    chk(wa == 32'h0000_8160, "R7 second write-back half1", wa, 32'h0000_8160);
    chk(mem_rd(32'h0000_8148) == 32'hDEAD_BEEF, "R7 written-back word half0",
        mem_rd(32'h0000_8148), 32'hDEAD_BEEF);
    chk(mem_rd(32'h0000_8170) == 32'h1234_5678, "R7 written-back word half1",
        mem_rd(32'h0000_8170), 32'h1234_5678);
    chk(mem_rd(32'h0000_8144) == iw(32'h0000_8144), "R7 untouched word written back",
        mem_rd(32'h0000_8144), iw(32'h0000_8144));
    access(0, 32'h0001_0164, 0, 1, 0, 0, "R9 other half invalid after new tag");

    // tag1 again: clean victim
    access(0, 32'h0000_8148, 0, 1, 0, 0, "R8 clean eviction");

    // write miss tag3: victim clean, only half0 valid
    access(1, 32'h0001_8150, 32'hA5A5_0001, 1, 0, 0, "R6 write miss allocate");
    access(0, 32'h0001_8154, 0, 0, 0, 1, "R6 neighbour word from memory");
    access(0, 32'h0001_8150, 0, 0, 0, 1, "R6 merged word");

    // dirty victim with only half0 valid
    access(0, 32'h0000_8160, 0, 1, 1, 0, "R7 dirty eviction one half");
    wa = (wb_addr_q.size() > 0) ? wb_addr_q.pop_front() : 32'hFFFF_FFFF;
    chk(wa == 32'h0001_8140, "R7 single write-back address", wa, 32'h0001_8140);
    chk(mem_rd(32'h0001_8150) == 32'hA5A5_0001, "R7 single write-back data",
        mem_rd(32'h0001_8150), 32'hA5A5_0001);
    chk(mem_rd(32'h0001_8160) == iw(32'h0001_8160), "R7 invalid half not written",
        mem_rd(32'h0001_8160), iw(32'h0001_8160));

    access(0, 32'h0000_0004, 0, 1, 0, 0, "R1 untouched set misses");
    chk(stab_bad == 0, "R10 memory request stable", 32'(stab_bad), 32'd0);
    chk(exp_q.size() == 0, "R2 all reads acknowledged", 32'(exp_q.size()), 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule